// File: doc/BRIEF.md
# Shift-only PI duty regulator

This block closes a current loop in the digital domain. At a fixed sample rate it asks an external converter for two readings: first the requested level, then the measured level. It subtracts the second from the first and runs an incremental proportional-plus-integral law whose coefficients are all powers of two, so the update needs only shifts, adders and a clamp. The clamped result is the new 8-bit duty value. That value drives a simple counter-compare PWM output, which takes a new value only when its counter wraps.

The converter link is a plain request/done handshake. The block drives a channel select and a one-cycle start pulse, then waits for a done strobe that comes with the conversion result. Only the most significant byte of each result is used. A busy output is high for the whole of each update. The state of the law (last error, last output) lives in the block. With the default parameters, an update falls every 100000 cycles, which is 0.5 ms at a 200 MHz clock.

Top module: `pi_duty_regulator`

## Requirements
- R1: An update begins on the cycle after the free-running tick counter reaches TICK_CYCLES-1, so updates are TICK_CYCLES cycles apart. A tick that arrives while an update is still in progress is dropped, and the next update waits for the following tick.
- R2: Each update issues two single-cycle start pulses. The first has adcSel=0 (requested level). The second has adcSel=1 (measured level) and is issued only after the done strobe for the first has arrived. No start pulse is issued while a conversion is outstanding.
- R3: Only bits [ADC_W-1:ADC_W-8] of adcData are used; the low bits have no effect. The error is the requested byte minus the measured byte, held as a signed 16-bit value.
- R4: The new output is (error >>> 1) - (previous error >>> 2) + previous output, where >>> is an arithmetic right shift on signed values.
- R5: A stored previous error equal to -1 is used as 0 before it is shifted.
- R6: A negative result becomes 0, and a result above 254 becomes 254.
- R7: At the end of an update, the error and the clamped output are stored as the previous values, and duty shows the clamped output. duty does not change at any other time.
- R8: busy is high from the first start pulse of an update until duty has been updated, and it falls on the same clock edge that writes duty.
- R9: Reset clears duty, the previous error and the previous output to 0, and leaves busy, adcStart and pwmOut low.
- R10: pwmOut is high while an 8-bit free-running counter is below the active compare value. The active compare value takes duty only when the counter wraps from 255 to 0, so in any 256-cycle window with a settled duty, pwmOut is high for exactly duty cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcDone | input | 1 | One-cycle strobe: conversion finished, adcData valid |
| adcData | input | ADC_W | Conversion result |
| adcStart | output | 1 | One-cycle conversion request |
| adcSel | output | 1 | Channel select: 0 requested level, 1 measured level |
| busy | output | 1 | High while an update is running |
| duty | output | 8 | Latest clamped duty value |
| pwmOut | output | 1 | PWM output |

## Verification
The first start pulse appears one cycle after the tick edge. duty and the fall of busy come together, one edge after the done strobe for the measured level has been captured. The bench therefore reads duty on the first falling clock edge at which busy is low, and it checks the spacing between start pulses for the requested level in whole clock cycles. A new duty reaches pwmOut only after the next counter wrap, which can take up to 256 cycles. The bench waits that long before it counts high cycles over a window of exactly 256 cycles. The converter model answers after a chosen latency, with junk in the unused low bits, and the bench checks the select value on every start pulse.

// File: rtl/pireg_pkg.sv
package pireg_pkg;

  typedef struct packed {
    logic capSp;   // latch requested-level byte
    logic capFb;   // latch measured-level byte
    logic commit;  // evaluate law, update state and duty
  } pireg_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_SP,
    ST_WAIT_SP,
    ST_REQ_FB,
    ST_WAIT_FB,
    ST_CALC
  } pireg_state_t;

endpackage

// File: rtl/pireg_ctrl.sv
module pireg_ctrl
  import pireg_pkg::*;
#(
  parameter int TICK_CYCLES = 100000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          adcDone,
  output logic          adcStart,
  output logic          adcSel,
  output logic          busy,
  output pireg_strobe_t strobes
);

  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] tickCnt;
  logic          tickNow;
  pireg_state_t  state, stateNext;

  assign tickNow = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (tickNow) tickCnt <= '0;
    else              tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (tickNow) stateNext = ST_REQ_SP;
      ST_REQ_SP:  stateNext = ST_WAIT_SP;
      ST_WAIT_SP: if (adcDone) stateNext = ST_REQ_FB;
      ST_REQ_FB:  stateNext = ST_WAIT_FB;
      ST_WAIT_FB: if (adcDone) stateNext = ST_CALC;
      ST_CALC:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign adcStart       = (state == ST_REQ_SP) || (state == ST_REQ_FB);
  assign adcSel         = (state == ST_REQ_FB) || (state == ST_WAIT_FB);
  assign busy           = (state != ST_IDLE);
  assign strobes.capSp  = (state == ST_WAIT_SP) && adcDone;
  assign strobes.capFb  = (state == ST_WAIT_FB) && adcDone;
  assign strobes.commit = (state == ST_CALC);

  // R1: no update leaves idle without a tick
  p_idle_until_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !tickNow) |=> (state == ST_IDLE));

  // R2: a start request lasts one cycle
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R2: the second request follows the first done and selects the measured level
  p_fb_after_sp_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_SP && adcDone) |=> (adcStart && adcSel));

endmodule

// File: rtl/pireg_datapath.sv
module pireg_datapath
  import pireg_pkg::*;
#(
  parameter int ADC_W  = 10,
  parameter int DUTY_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pireg_strobe_t     strobes,
  input  logic [ADC_W-1:0]  adcData,
  output logic [DUTY_W-1:0] dutyReg
);

  localparam int PAD = ACC_W - DUTY_W;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << DUTY_W) - 2);

  logic [DUTY_W-1:0]        sampleTop;
  logic [DUTY_W-1:0]        spReg, fbReg;
  logic signed [ACC_W-1:0]  prevErr;
  logic signed [ACC_W-1:0]  errNow, prevAdj, prevOutS, sumNow;
  logic [DUTY_W-1:0]        clampNow;

  assign sampleTop = adcData[ADC_W-1 -: DUTY_W];

  generate
    if (ADC_W > DUTY_W) begin : g_low_bits
      logic unusedLowBits;
      assign unusedLowBits = ^adcData[ADC_W-DUTY_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spReg <= '0;
      fbReg <= '0;
    end else begin
      if (strobes.capSp) spReg <= sampleTop;
      if (strobes.capFb) fbReg <= sampleTop;
    end
  end

  always_comb begin
    errNow   = $signed({{PAD{1'b0}}, spReg}) - $signed({{PAD{1'b0}}, fbReg});
    prevAdj  = (&prevErr) ? '0 : prevErr;
    prevOutS = $signed({{PAD{1'b0}}, dutyReg});
    sumNow   = (errNow >>> 1) - (prevAdj >>> 2) + prevOutS;
    if (sumNow < 0)           clampNow = '0;
    else if (sumNow > SAT_HI) clampNow = SAT_HI[DUTY_W-1:0];
    else                      clampNow = sumNow[DUTY_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevErr <= '0;
      dutyReg <= '0;
    end else if (strobes.commit) begin
      prevErr <= errNow;
      dutyReg <= clampNow;
    end
  end

  // R6: duty never exceeds the upper clamp
  p_duty_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    dutyReg <= SAT_HI[DUTY_W-1:0]);

  // R7: duty and stored error change only on commit
  p_hold_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(dutyReg) && $stable(prevErr)));

endmodule

// File: rtl/pireg_pwm.sv
module pireg_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyReg,
  output logic              pwmOut
);

  logic [DUTY_W-1:0] cnt;
  logic [DUTY_W-1:0] cmpActive;
  logic              wrapNow;

  assign wrapNow = &cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      cmpActive <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrapNow) cmpActive <= dutyReg;
    end
  end

  assign pwmOut = (cnt < cmpActive);

  // R10: the active compare value changes only across a counter wrap
  p_load_at_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrapNow |=> $stable(cmpActive));

endmodule

// File: rtl/pi_duty_regulator.sv
module pi_duty_regulator
  import pireg_pkg::*;
#(
  parameter int TICK_CYCLES = 100000,
  parameter int ADC_W       = 10,
  parameter int DUTY_W      = 8,
  parameter int ACC_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcDone,
  input  logic [ADC_W-1:0]  adcData,
  output logic              adcStart,
  output logic              adcSel,
  output logic              busy,
  output logic [DUTY_W-1:0] duty,
  output logic              pwmOut
);

  pireg_strobe_t strobes;

  pireg_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .adcDone  (adcDone),
    .adcStart (adcStart),
    .adcSel   (adcSel),
    .busy     (busy),
    .strobes  (strobes)
  );

  pireg_datapath #(.ADC_W(ADC_W), .DUTY_W(DUTY_W), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .adcData (adcData),
    .dutyReg (duty)
  );

  pireg_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk     (clk),
    .rstN    (rstN),
    .dutyReg (duty),
    .pwmOut  (pwmOut)
  );

  // R8: busy drops on the edge that ends the update
  p_busy_ends_with_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strobes.commit));

endmodule

// File: tb/sim_pi_duty_regulator.sv
`timescale 1ns/1ps
module sim_pi_duty_regulator;

  localparam int TICK = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       adcDone = 1'b0;
  logic [9:0] adcData = '0;
  logic       adcStart, adcSel, busy, pwmOut;
  logic [7:0] duty;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lat = 2;
  int curSp = 0, curFb = 0;
  int lastSpCyc = 0, prevSpCyc = 0;
  logic phaseSel = 1'b0;
  int refPrev = 0, refOut = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pi_duty_regulator #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rstN(rstN), .adcDone(adcDone), .adcData(adcData),
    .adcStart(adcStart), .adcSel(adcSel), .busy(busy), .duty(duty), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model
  initial begin
    logic selNow;
    @(negedge clk);
    forever begin
      if (rstN && adcStart === 1'b1) begin
        check(adcSel == phaseSel, "R2 channel order", adcSel, phaseSel);
        check(busy == 1'b1, "R8 busy during request", busy, 1);
        if (!adcSel) begin prevSpCyc = lastSpCyc; lastSpCyc = cyc; end
        selNow = adcSel;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (adcStart) check(1'b0, "R2 request while outstanding", 1, 0);
        end
        adcData = {(selNow ? curFb[7:0] : curSp[7:0]), 2'(cyc)};
        adcDone = 1'b1;
        @(negedge clk);
        adcDone = 1'b0;
        phaseSel = ~phaseSel;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic run_update(input int sp, input int fb, input string tag);
    int e, pa, y;
    while (busy) @(negedge clk);
    curSp = sp; curFb = fb;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    e  = sp - fb;
    pa = (refPrev == -1) ? 0 : refPrev;
    y  = (e >>> 1) - (pa >>> 2) + refOut;
    if (y < 0) y = 0;
    if (y > 254) y = 254;
    refPrev = e;
    refOut  = y;
    check(duty == y[7:0], tag, duty, y);
  endtask

  task automatic pwm_count(input int exp, input string tag);
    int hi = 0;
    repeat (300) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (pwmOut) hi++;
      @(negedge clk);
    end
    check(hi == exp, tag, hi, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check(duty == 0, "R9 duty reset", duty, 0);
    check(busy == 0, "R9 busy reset", busy, 0);
    check(adcStart == 0, "R9 start reset", adcStart, 0);
    check(pwmOut == 0, "R9 pwm reset", pwmOut, 0);
    rstN = 1'b1;

    // R4 directed: err 80 -> 40
    run_update(100, 20, "R4 first step");
    check(duty == 40, "R4 value 40", duty, 40);
    // err -1 -> -1 - 20 + 40 = 19
    run_update(40, 41, "R4 negative step");
    check(duty == 19, "R4 value 19", duty, 19);
    // R5: previous -1 used as 0 -> stays 19 (would be 20 otherwise)
    run_update(50, 50, "R5 minus one quirk");
    check(duty == 19, "R5 value 19", duty, 19);
    run_update(77, 77, "R7 steady");
    pwm_count(19, "R10 pwm mid");

    // R1 spacing
    run_update(77, 77, "R7 steady");
    run_update(77, 77, "R7 steady");
    check(lastSpCyc - prevSpCyc == TICK, "R1 tick spacing", lastSpCyc - prevSpCyc, TICK);
    lat = 40;
    run_update(77, 77, "R1 slow update");
    lat = 2;
    run_update(77, 77, "R1 after slow");
    check(lastSpCyc - prevSpCyc == 2 * TICK, "R1 dropped tick", lastSpCyc - prevSpCyc, 2 * TICK);
    run_update(77, 77, "R1 recovered");
    check(lastSpCyc - prevSpCyc == TICK, "R1 tick spacing again", lastSpCyc - prevSpCyc, TICK);

    // R6 upper clamp
    for (int k = 0; k < 6; k++) run_update(255, 0, "R6 climb");
    check(duty == 254, "R6 upper clamp", duty, 254);
    pwm_count(254, "R10 pwm high");
    run_update(255, 0, "R6 hold high");
    // R6 lower clamp
    for (int k = 0; k < 6; k++) run_update(0, 255, "R6 fall");
    check(duty == 0, "R6 lower clamp", duty, 0);
    pwm_count(0, "R10 pwm zero");
    run_update(0, 255, "R6 hold low");

    // sweep, R3 low bits carry junk from the model
    for (int k = 0; k < 300; k++)
      run_update((k * 37 + 5) % 256, (k * 91 + 13 + (k % 3)) % 256, "R3 R4 R7 sweep");
    for (int k = 0; k < 64; k++)
      run_update(128 + (k % 5), 129 + (k % 3), "R5 small errors");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule